// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Port

This block is the host-facing register front end of a two-channel serial communications controller. A host reaches each channel through two byte locations: a command location, through which sixteen write registers and sixteen read registers per channel are reached indirectly (a register pointer is written first, the value second), and a data location, which sends transmit bytes out on a strobed byte output and takes received bytes from a per-channel receive buffer.

A channel can loop its transmitted bytes straight back into its own receive buffer. Two extra addresses reach the command and data locations of channel 0, and an older access style is accepted in which the byte rides in the upper half of a 16-bit word. A single shared interrupt-pending register collects transmit and receive events and drives one interrupt line. Baud generation, the line itself and DMA lie outside this block.

Top module: `sio_regport`

## Requirements
- R1: Addresses 0x00-0x0F decode with bit 3 as the channel and bits 2:0 as the offset; offset 1 is the command location and offset 5 is the data location. Offsets 2, 3, 6, 7 and every address from 0x10 upward (other than 0x1F) are ignored, and a read there returns 0.
- R2: The first write to a channel's command location loads bits 3:0 of the byte into that channel's register pointer; the next write there stores the byte in the selected write register, after which the pointer returns to 0 and the next write is again a pointer load.
- R3: A read of the command location returns the read register that the pointer selects (RR0: bit 2 always 1 for transmit empty, bit 0 set while the receive buffer holds data; RR1: bit 5 the overrun flag; RR3: the shared pending register; RR12, RR13: see R4; all others 0), then returns the pointer to 0 and cancels a pending pointer load.
- R4: Read registers 12 and 13 of a channel show the contents of that channel's write registers 12 and 13, refreshed on every write-register update.
- R5: Address 0x0F acts as the command location of channel 0 and address 0x1F as the data location of channel 0.
- R6: A write at offset 0 or 4 whose low byte is zero, and any read at offset 0 or 4, is handled as an access at offset 1 or 5 respectively using bits 15:8 as the byte; such a read returns its byte in bits 15:8. A write at offset 0 or 4 with a nonzero low byte is ignored.
- R7: A data write drives the byte on tx_byte, the channel on tx_chan and a one-cycle tx_strobe in the cycle after the access.
- R8: When bit 4 of write register 14 of a channel is set, a data write on that channel also pushes the byte into that channel's receive buffer.
- R9: A data read returns the oldest byte of the channel's receive buffer and removes it, or 0 when the buffer is empty; every data read clears the whole pending register and deasserts irq.
- R10: Each receive buffer holds RX_DEPTH bytes in arrival order; a push into a full buffer is dropped and sets that channel's overrun flag, which stays set until reset.
- R11: With bit 3 of write register 9 set in either channel, a data write sets pending bit 4 (channel 0) or bit 1 (channel 1) when bit 1 of that channel's write register 1 is set, and a loopback push sets pending bit 5 (channel 0) or bit 2 (channel 1) when bit 4 of that channel's write register 1 is set; irq is high while any pending bit is set, and a read of RR3 on either channel clears the register.
- R12: After reset bus_rdata is 0, irq and tx_strobe are low, all pointers are 0 and all write registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after a read |
| tx_byte | output | 8 | Transmitted byte |
| tx_chan | output | 1 | Channel of the transmitted byte |
| tx_strobe | output | 1 | One-cycle pulse marking tx_byte valid |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a full receive buffer followed by a dropped byte: there is no receive input, so the bench first turns on loopback through the two-step pointer protocol and then sends RX_DEPTH plus one bytes, expecting every one on the transmit output, the overrun bit in RR1, and exactly RX_DEPTH bytes returned in order. The pointer state machine is likewise driven into its less obvious corners, such as a read between a pointer load and its value, and a legacy write with a nonzero low byte that must leave the pointer untouched.

// File: rtl/sio_pkg.sv
// Package: shared types and register/bit positions for the serial register port.
// Assumes two channels selected by one address bit; positions below are
// decoded by the register logic and the interrupt logic.
package sio_pkg;
    localparam int NUM_CH   = 2;
    localparam int NUM_REG  = 16;
    localparam int PTR_W    = $clog2(NUM_REG);

    // Write-register indices that carry control bits
    localparam int W_IE     = 1;
    localparam int W_MASTER = 9;
    localparam int W_TC_LO  = 12;
    localparam int W_TC_HI  = 13;
    localparam int W_MISC   = 14;

    // Control bit positions
    localparam int B_TX_IE  = 1;
    localparam int B_RX_IE  = 4;
    localparam int B_MIE    = 3;
    localparam int B_LOOP   = 4;

    // Shared pending-register bit positions
    localparam int P_RX0 = 5;
    localparam int P_TX0 = 4;
    localparam int P_RX1 = 2;
    localparam int P_TX1 = 1;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CMD  = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/sio_addr_decode.sv
// Module: sio_addr_decode
// Turns a bus address and write data into an access kind, a channel, the
// effective byte and a legacy (upper-byte) flag. Purely combinational.
// Assumes reads carry no meaningful write data.
module sio_addr_decode
    import sio_pkg::*;
(
    input  logic [7:0]  addr,
    input  logic        write,
    input  logic [15:0] wdata,
    output acc_kind_t   kind,
    output logic        chan,
    output logic        legacy,
    output logic [7:0]  byte_in
);
    // Map address to location; aliases and the shifted-byte form first
    always_comb begin
        kind    = ACC_NONE;
        chan    = addr[3];
        legacy  = 1'b0;
        byte_in = wdata[7:0];
        if (addr == 8'h0F) begin
            kind = ACC_CMD;
            chan = 1'b0;
        end else if (addr == 8'h1F) begin
            kind = ACC_DATA;
            chan = 1'b0;
        end else if (addr[7:4] == 4'h0) begin
            case (addr[2:0])
                3'd1: kind = ACC_CMD;
                3'd5: kind = ACC_DATA;
                3'd0, 3'd4: begin
                    if (!write || wdata[7:0] == 8'h00) begin
                        legacy  = 1'b1;
                        byte_in = wdata[15:8];
                        kind    = addr[2] ? ACC_DATA : ACC_CMD;
                    end
                end
                default: kind = ACC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sio_rx_fifo.sv
// Module: sio_rx_fifo
// Circular receive buffer of DEPTH bytes. Push into a full buffer is dropped
// and sets a sticky overrun flag. Pop of an empty buffer does nothing.
// Assumes push and pop never coincide (one bus access per cycle).
module sio_rx_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [7:0]                 push_data,
    input  logic                       pop,
    output logic [7:0]                 head,
    output logic                       empty,
    output logic                       overrun,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          full;

    assign full  = (cnt_q == LW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign head  = mem[rp_q];
    assign level = cnt_q;

    // Storage write, no reset needed for data
    always_ff @(posedge clk) begin
        if (push && !full) mem[wp_q] <= push_data;
    end

    // Pointer, count and overrun bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q    <= '0;
            rp_q    <= '0;
            cnt_q   <= '0;
            overrun <= 1'b0;
        end else if (push) begin
            if (full) begin
                overrun <= 1'b1;
            end else begin
                wp_q  <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (pop && !empty) begin
            rp_q  <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sio_chan_regs.sv
// Module: sio_chan_regs
// One channel's pointer state machine, write-register file and read mux.
// Assumes cmd_wr/cmd_rd are already qualified for this channel.
module sio_chan_regs
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       cmd_rd,
    input  logic [7:0] wbyte,
    input  logic       rx_avail,
    input  logic       rx_ovr,
    input  logic [7:0] pend_view,
    output logic [7:0] rd_val,
    output logic       sel_busy,
    output logic       ptr_on_pend,
    output logic       loop_en,
    output logic       tx_ie,
    output logic       rx_ie,
    output logic       master_ie
);
    logic [PTR_W-1:0] ptr_q;
    logic             sel_q;
    logic [7:0]       wr_q [NUM_REG];
    logic [7:0]       tc_lo_q, tc_hi_q;

    // Two-step pointer/value protocol and write-register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            sel_q   <= 1'b0;
            tc_lo_q <= '0;
            tc_hi_q <= '0;
            for (int i = 0; i < NUM_REG; i++) wr_q[i] <= '0;
        end else if (cmd_wr) begin
            if (!sel_q) begin
                ptr_q <= wbyte[PTR_W-1:0];
                sel_q <= 1'b1;
            end else begin
                wr_q[ptr_q] <= wbyte;
                tc_lo_q     <= (ptr_q == PTR_W'(W_TC_LO)) ? wbyte : wr_q[W_TC_LO];
                tc_hi_q     <= (ptr_q == PTR_W'(W_TC_HI)) ? wbyte : wr_q[W_TC_HI];
                ptr_q       <= '0;
                sel_q       <= 1'b0;
            end
        end else if (cmd_rd) begin
            ptr_q <= '0;
            sel_q <= 1'b0;
        end
    end

    // Read-register selection
    always_comb begin
        case (ptr_q)
            4'd0:    rd_val = {5'b0, 1'b1, 1'b0, rx_avail};
            4'd1:    rd_val = {2'b0, rx_ovr, 5'b0};
            4'd3:    rd_val = pend_view;
            4'd12:   rd_val = tc_lo_q;
            4'd13:   rd_val = tc_hi_q;
            default: rd_val = 8'h00;
        endcase
    end

    assign sel_busy    = sel_q;
    assign ptr_on_pend = (ptr_q == PTR_W'(3));
    assign loop_en     = wr_q[W_MISC][B_LOOP];
    assign tx_ie       = wr_q[W_IE][B_TX_IE];
    assign rx_ie       = wr_q[W_IE][B_RX_IE];
    assign master_ie   = wr_q[W_MASTER][B_MIE];
endmodule

// File: rtl/sio_regport.sv
// Module: sio_regport
// Host register port of a two-channel serial controller: address decode,
// per-channel indirect registers, loopback receive buffers, transmit strobe
// and a shared interrupt-pending register. Read data is registered.
// Assumes at most one access per cycle.
module sio_regport
    import sio_pkg::*;
#(
    parameter int RX_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [7:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [7:0]  tx_byte,
    output logic        tx_chan,
    output logic        tx_strobe,
    output logic        irq
);
    localparam int LVL_W = $clog2(RX_DEPTH + 1);

    acc_kind_t  kind;
    logic       chan, legacy;
    logic [7:0] byte_in;
    logic       acc_ok, cmd_wr, cmd_rd, data_wr, data_rd;

    logic [7:0]       cmd_val [NUM_CH];
    logic [7:0]       rx_head [NUM_CH];
    logic [LVL_W-1:0] rx_level [NUM_CH];
    logic [NUM_CH-1:0] rx_empty, rx_ovr, push, sel_busy, ptr_on_pend;
    logic [NUM_CH-1:0] loop_en, tx_ie, rx_ie, mie;
    logic [7:0] pend_q, pend_set, rd_byte;
    logic       master_ie, pend_clr;

    sio_addr_decode u_dec (
        .addr(bus_addr), .write(bus_write), .wdata(bus_wdata),
        .kind(kind), .chan(chan), .legacy(legacy), .byte_in(byte_in)
    );

    assign acc_ok  = bus_valid && (kind != ACC_NONE);
    assign cmd_wr  = acc_ok &&  bus_write && (kind == ACC_CMD);
    assign cmd_rd  = acc_ok && !bus_write && (kind == ACC_CMD);
    assign data_wr = acc_ok &&  bus_write && (kind == ACC_DATA);
    assign data_rd = acc_ok && !bus_write && (kind == ACC_DATA);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign push[c] = data_wr && (chan == 1'(c)) && loop_en[c];

        sio_chan_regs u_regs (
            .clk(clk), .rst_n(rst_n),
            .cmd_wr(cmd_wr && chan == 1'(c)),
            .cmd_rd(cmd_rd && chan == 1'(c)),
            .wbyte(byte_in), .rx_avail(!rx_empty[c]), .rx_ovr(rx_ovr[c]),
            .pend_view(pend_q), .rd_val(cmd_val[c]), .sel_busy(sel_busy[c]),
            .ptr_on_pend(ptr_on_pend[c]), .loop_en(loop_en[c]),
            .tx_ie(tx_ie[c]), .rx_ie(rx_ie[c]), .master_ie(mie[c])
        );

        sio_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
            .clk(clk), .rst_n(rst_n), .push(push[c]), .push_data(byte_in),
            .pop(data_rd && chan == 1'(c)), .head(rx_head[c]),
            .empty(rx_empty[c]), .overrun(rx_ovr[c]), .level(rx_level[c])
        );
    end

    assign master_ie = |mie;
    assign pend_clr  = data_rd || (cmd_rd && ptr_on_pend[chan]);

    // Pending events raised by this cycle's data write
    always_comb begin
        pend_set = '0;
        if (data_wr && master_ie) begin
            if (tx_ie[chan])                 pend_set[chan ? P_TX1 : P_TX0] = 1'b1;
            if (push[chan] && rx_ie[chan])   pend_set[chan ? P_RX1 : P_RX0] = 1'b1;
        end
    end

    // Shared pending register: cleared by data reads and RR3 reads
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (pend_clr) pend_q <= '0;
        else               pend_q <= pend_q | pend_set;
    end

    assign irq = |pend_q;

    // Byte selected for a read of a mapped location
    always_comb begin
        if (kind == ACC_CMD) rd_byte = cmd_val[chan];
        else                 rd_byte = rx_empty[chan] ? 8'h00 : rx_head[chan];
    end

    // Registered read data, placed in the upper byte for legacy reads
    always_ff @(posedge clk) begin
        if (!rst_n)                      bus_rdata <= '0;
        else if (bus_valid && !bus_write) begin
            if (!acc_ok)     bus_rdata <= '0;
            else if (legacy) bus_rdata <= {rd_byte, 8'h00};
            else             bus_rdata <= {8'h00, rd_byte};
        end
    end

    // Transmit byte and one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
            tx_chan   <= 1'b0;
        end else begin
            tx_strobe <= data_wr;
            if (data_wr) begin
                tx_byte <= byte_in;
                tx_chan <= chan;
            end
        end
    end
endmodule

// File: rtl/sio_regport_chk.sv
// Module: sio_regport_chk
// Property checker for sio_regport, attached by bind below.
// Assumes it observes the top-level ports plus buffer levels and select state.
module sio_regport_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [7:0]       bus_addr,
    input logic [15:0]      bus_rdata,
    input logic             tx_strobe,
    input logic             irq,
    input logic [LVL_W-1:0] lvl0,
    input logic [LVL_W-1:0] lvl1,
    input logic             sel0
);
    a_r7_tx_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bus_valid && bus_write));

    a_r9_data_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write &&
         (bus_addr == 8'h05 || bus_addr == 8'h0D || bus_addr == 8'h1F)) |=> !irq);

    a_r1_high_addr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[7:4] != 4'h0 && bus_addr != 8'h1F)
        |=> (bus_rdata == 16'h0000));

    a_r10_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl0 <= LVL_W'(DEPTH)) && (lvl1 <= LVL_W'(DEPTH)));

    a_r3_read_cancels_select: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 8'h01) |=> !sel0);
endmodule

bind sio_regport sio_regport_chk #(.DEPTH(RX_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tx_strobe(tx_strobe),
    .irq(irq), .lvl0(rx_level[0]), .lvl1(rx_level[1]), .sel0(sel_busy[0])
);

// File: tb/tb_sio_regport.sv
// Scoreboard bench: driver tasks queue expected read data and transmit
// events; monitors compare them against the outputs at the falling edge.
module tb_sio_regport;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_chan;
    logic        tx_strobe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic saw_rd = 1'b0;

    logic [15:0] rd_exp [$];
    string       rd_tag [$];
    logic [8:0]  tx_exp [$];
    string       tx_tag [$];

    always #10 clk = ~clk;

    sio_regport #(.RX_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_chan(tx_chan), .tx_strobe(tx_strobe), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle, entered and left at a falling edge
    task automatic acc(input logic w, input logic [7:0] a, input logic [15:0] d);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        acc(1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
        rd_exp.push_back(exp);
        rd_tag.push_back(req);
        acc(1'b0, a, 16'h0000);
    endtask

    task automatic send(input logic [7:0] a, input logic [15:0] d, input logic ch,
                        input logic [7:0] b, input string req);
        tx_exp.push_back({ch, b});
        tx_tag.push_back(req);
        wr(a, d);
    endtask

    // Select a register and write it (two-step protocol)
    task automatic setreg(input logic [7:0] cmd, input logic [3:0] idx, input logic [7:0] v);
        wr(cmd, {12'h0, idx});
        wr(cmd, {8'h0, v});
    endtask

    task automatic getreg(input logic [7:0] cmd, input logic [3:0] idx,
                          input logic [15:0] exp, input string req);
        wr(cmd, {12'h0, idx});
        rd(cmd, exp, req);
    endtask

    // Read monitor: record reads at the edge, compare at the next falling edge
    always @(posedge clk) saw_rd <= bus_valid && !bus_write;

    always @(negedge clk) begin
        if (saw_rd) begin
            if (rd_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL read-scoreboard actual=%h expected=none", bus_rdata);
            end else begin
                chk(rd_tag.pop_front(), bus_rdata, rd_exp.pop_front());
            end
        end
        if (tx_strobe) begin
            if (tx_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected strobe actual=%h expected=none", {tx_chan, tx_byte});
            end else begin
                chk(tx_tag.pop_front(), {7'h0, tx_chan, tx_byte}, {7'h0, tx_exp.pop_front()});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12 rdata", bus_rdata, 16'h0);
        chk("R12 irq", {15'h0, irq}, 16'h0);
        chk("R12 strobe", {15'h0, tx_strobe}, 16'h0);
        rd(8'h01, 16'h0004, "R12 pointer at RR0");

        // R2 R4: value written through pointer reads back in RR12/RR13
        setreg(8'h01, 4'd12, 8'h5A);
        getreg(8'h01, 4'd12, 16'h005A, "R4 RR12 ch0");
        rd(8'h01, 16'h0004, "R3 pointer back at RR0");
        setreg(8'h09, 4'd13, 8'hC3);
        getreg(8'h09, 4'd13, 16'h00C3, "R4 RR13 ch1");
        getreg(8'h09, 4'd12, 16'h0000, "R4 ch1 separate");

        // R2: after a value write the next write is a pointer load
        setreg(8'h01, 4'd12, 8'h11);
        setreg(8'h01, 4'd13, 8'h22);
        getreg(8'h01, 4'd12, 16'h0011, "R2 RR12 after re-select");
        getreg(8'h01, 4'd13, 16'h0022, "R2 RR13 after re-select");

        // R3: read between pointer load and value cancels the load
        wr(8'h01, 16'h000C);
        rd(8'h01, 16'h0011, "R3 read selected");
        setreg(8'h01, 4'd12, 8'h33);
        getreg(8'h01, 4'd12, 16'h0033, "R3 select cancelled");

        // R1: unmapped locations
        rd(8'h02, 16'h0000, "R1 offset 2");
        rd(8'h0E, 16'h0000, "R1 offset 6 ch1");
        rd(8'h23, 16'h0000, "R1 high address");
        wr(8'h07, 16'h00AA);
        wr(8'h41, 16'h00AA);
        getreg(8'h01, 4'd12, 16'h0033, "R1 ignored writes");

        // R7: transmit on both channels; R9 empty read
        send(8'h05, 16'h0041, 1'b0, 8'h41, "R7 tx ch0");
        send(8'h0D, 16'h0042, 1'b1, 8'h42, "R7 tx ch1");
        rd(8'h05, 16'h0000, "R9 empty read");

        // R8: loopback on channel 1
        setreg(8'h09, 4'd14, 8'h10);
        send(8'h0D, 16'h0061, 1'b1, 8'h61, "R8 tx lb1");
        send(8'h0D, 16'h0062, 1'b1, 8'h62, "R8 tx lb2");
        rd(8'h09, 16'h0005, "R8 RR0 rx available");
        rd(8'h0D, 16'h0061, "R8 oldest first");
        rd(8'h0D, 16'h0062, "R8 second");
        rd(8'h0D, 16'h0000, "R9 drained");
        rd(8'h09, 16'h0004, "R8 RR0 empty");
        rd(8'h05, 16'h0000, "R8 ch0 untouched");

        // R5: aliases
        setreg(8'h0F, 4'd12, 8'h99);
        getreg(8'h01, 4'd12, 16'h0099, "R5 cmd alias write");
        getreg(8'h0F, 4'd12, 16'h0099, "R5 cmd alias read");
        send(8'h1F, 16'h0055, 1'b0, 8'h55, "R5 data alias tx");
        setreg(8'h01, 4'd14, 8'h10);
        send(8'h1F, 16'h0066, 1'b0, 8'h66, "R5 data alias lb");
        rd(8'h1F, 16'h0066, "R5 data alias read");

        // R6: upper-byte legacy accesses
        wr(8'h00, 16'h0C00);
        wr(8'h00, 16'h3300);
        rd(8'h00, 16'h0400, "R6 legacy RR0");
        wr(8'h00, 16'h0C00);
        rd(8'h00, 16'h3300, "R6 legacy RR12");
        send(8'h04, 16'h7700, 1'b0, 8'h77, "R6 legacy tx");
        rd(8'h04, 16'h7700, "R6 legacy data read");
        send(8'h0C, 16'h4400, 1'b1, 8'h44, "R6 legacy tx ch1");
        rd(8'h0D, 16'h0044, "R6 legacy push ch1");
        wr(8'h00, 16'h0C05);
        getreg(8'h01, 4'd12, 16'h0033, "R6 nonzero low byte ignored");

        // R10: fill past depth on channel 0
        for (int i = 0; i <= DEPTH; i++)
            send(8'h05, 16'h0080 + 16'(i), 1'b0, 8'h80 + 8'(i), "R10 fill tx");
        getreg(8'h01, 4'd1, 16'h0020, "R10 overrun set");
        for (int i = 0; i < DEPTH; i++)
            rd(8'h05, 16'h0080 + 16'(i), "R10 order kept");
        rd(8'h05, 16'h0000, "R10 extra byte dropped");
        getreg(8'h01, 4'd1, 16'h0020, "R10 overrun sticky");

        // R11: interrupts
        setreg(8'h01, 4'd9, 8'h08);
        setreg(8'h01, 4'd1, 8'h12);
        chk("R11 no irq before event", {15'h0, irq}, 16'h0);
        send(8'h05, 16'h00A1, 1'b0, 8'hA1, "R11 tx");
        chk("R11 irq raised", {15'h0, irq}, 16'h1);
        getreg(8'h01, 4'd3, 16'h0030, "R11 pending ch0 bits");
        chk("R11 RR3 read clears", {15'h0, irq}, 16'h0);
        rd(8'h05, 16'h00A1, "R9 pop after irq");
        setreg(8'h09, 4'd1, 8'h02);
        send(8'h0D, 16'h00B2, 1'b1, 8'hB2, "R11 tx ch1");
        chk("R11 irq ch1", {15'h0, irq}, 16'h1);
        getreg(8'h09, 4'd3, 16'h0002, "R11 pending ch1 via ch1");
        send(8'h0D, 16'h00B3, 1'b1, 8'hB3, "R11 tx ch1 again");
        rd(8'h0D, 16'h00B2, "R9 data read with irq");
        chk("R9 data read clears irq", {15'h0, irq}, 16'h0);
        getreg(8'h01, 4'd3, 16'h0000, "R9 pending cleared");
        rd(8'h0D, 16'h00B3, "R9 second pop");
        setreg(8'h01, 4'd9, 8'h00);
        send(8'h05, 16'h00C3, 1'b0, 8'hC3, "R11 master off tx");
        chk("R11 master off no irq", {15'h0, irq}, 16'h0);
        rd(8'h05, 16'h00C3, "R11 master off pop");

        repeat (3) @(negedge clk);
        checks++;
        if (tx_exp.size() != 0 || rd_exp.size() != 0) begin
            errors++;
            $display("FAIL R7 missing events actual=%0d expected=0",
                     tx_exp.size() + rd_exp.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule